// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

A synthesizable behavioural model of a byte-wide memory whose cells can only be cleared from one to zero. It has a 2**ADDR_W by 8 array. ADDR_W = 15 gives the full 32,768-word part. The default of 10 keeps elaboration small. A two-line output control uses an active-low chip enable and an active-low output enable. Together with a high-voltage programming flag and a signature-select flag, these pick one of seven modes: read, output-disable, standby, signature, program, program-inhibit and verify.

Analog levels, real access delays and UV exposure are not modelled. The high-voltage condition is a plain flag, and the data access time is a parameter, `RD_LAT`, counted in clock cycles. A test-only synchronous erase input returns the whole array to the blank state in one edge. `dout_en` stands in for the tri-state enable of a real output pin. While it is low, `dout` reads 0.

Top module: `otp_byte_mem`

## Requirements
- R1: The array holds 2**ADDR_W words of 8 bits. After reset, every word reads 0xFF.
- R2: With vpp_hi=0, ce_n=0, oe_n=0 and sig_sel=0 (read), dout_en is 1 and, once valid, dout is the stored byte at addr.
- R3: With vpp_hi=0, ce_n=0 and oe_n=1 (output-disable), dout_en, dout_valid and dout are all 0.
- R4: With vpp_hi=0 and ce_n=1 (standby), dout_en is 0 whatever the level of oe_n.
- R5: A program pulse has vpp_hi=1, oe_n=1 and ce_n=0 for at least one rising edge. At the first edge where ce_n is sampled high after it, the word at the last captured addr becomes its old value AND the last captured din.
- R6: Programming never turns a 0 bit back to 1. Writing 0xF0 over 0xA5 leaves 0xA0, and writing 0xFF leaves a word unchanged.
- R7: With vpp_hi=1 and ce_n=1, oe_n=1 (inhibit), or with vpp_hi=1, ce_n=0, oe_n=0, no word changes and dout_en is 0.
- R8: With vpp_hi=1, ce_n=1 and oe_n=0 (verify), dout_en is 1 and, once valid, dout is the stored byte at addr.
- R9: With vpp_hi=0, ce_n=0, oe_n=0 and sig_sel=1 (signature), dout shows 0x20 when addr[0]=0 and 0x8D when addr[0]=1.
- R10: When a driving mode (read, verify, signature) is entered from a non-driving one, dout_valid rises RD_LAT rising edges later and stays high while the mode holds. While dout_valid is 0, dout is 0 even though dout_en is 1.
- R11: When erase is sampled high, every word reads 0xFF from the next cycle on. Erase takes priority over a program commit at the same edge.
- R12: If a program pulse ends because oe_n falls or vpp_hi falls while ce_n is still low, nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address; bit 0 selects the signature byte |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage present |
| sig_sel | input | 1 | Signature select (stands for the raised address level) |
| din | input | 8 | Byte to program |
| erase | input | 1 | Test-only synchronous blanking of the whole array |
| dout | output | 8 | Output byte, 0 while not valid |
| dout_en | output | 1 | Output drive enable (low means high impedance) |
| dout_valid | output | 1 | Output byte has met the access latency |

## Verification
The only pair of functions that can fall on the same edge is a program commit and a test erase. The bench provokes this by raising erase at the very negative edge where it returns ce_n high to end a program pulse of 0x00. It judges the outcome by reading back 0xFF, both from the programmed word and from a word programmed earlier, so that erase is seen to win. A cancelled pulse, closed by oe_n rather than ce_n, is judged the same way.

// File: rtl/otp_pkg.sv
package otp_pkg;
   localparam int unsigned DATA_W = 8;
   localparam logic [DATA_W-1:0] MFR_CODE = 8'h20;
   localparam logic [DATA_W-1:0] DEV_CODE = 8'h8D;

   typedef enum logic [2:0] {
      M_STANDBY,
      M_OUT_DIS,
      M_READ,
      M_SIG,
      M_PROGRAM,
      M_INHIBIT,
      M_VERIFY
   } otp_mode_e;

   function automatic logic mode_drives(otp_mode_e m);
      return (m == M_READ) || (m == M_SIG) || (m == M_VERIFY);
   endfunction
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
   import otp_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      vpp_hi,
   input  logic      sig_sel,
   output otp_mode_e mode
);
   always_comb begin
      if (!vpp_hi) begin
         if (ce_n)      mode = M_STANDBY;
         else if (oe_n) mode = M_OUT_DIS;
         else           mode = sig_sel ? M_SIG : M_READ;
      end else begin
         unique case ({ce_n, oe_n})
            2'b01:   mode = M_PROGRAM;
            2'b10:   mode = M_VERIFY;
            default: mode = M_INHIBIT;
         endcase
      end
   end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DEPTH-1:0]  touched;
   logic [DATA_W-1:0] old_word;

   assign old_word = touched[wr_addr] ? cells[wr_addr] : BLANK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             touched          <= '0;
      else if (erase)         touched          <= '0;
      else if (wr_en)         touched[wr_addr] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !erase) cells[wr_addr] <= old_word & wr_data;
   end

   assign rd_data = touched[rd_addr] ? cells[rd_addr] : BLANK;

   AST_ERASE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (rd_data == BLANK)); // R11

   AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !erase && rd_addr == wr_addr) |=>
         ((rd_addr != $past(rd_addr)) || ((rd_data & ~$past(rd_data)) == '0))); // R6
endmodule

// File: rtl/otp_rd_timer.sv
module otp_rd_timer #(
   parameter int unsigned RD_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drive,
   output logic valid
);
   localparam int unsigned CNT_W = $clog2(RD_LAT + 2);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RD_LAT);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!drive)        cnt <= '0;
      else if (cnt != LAST)   cnt <= cnt + 1'b1;
   end

   assign valid = drive && (cnt == LAST);

   AST_VALID_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      ((RD_LAT > 0) && $rose(valid)) |-> $past(drive)); // R10
endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
   import otp_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned RD_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   input  logic              sig_sel,
   input  logic [7:0]        din,
   input  logic              erase,
   output logic [7:0]        dout,
   output logic              dout_en,
   output logic              dout_valid
);
   if (ADDR_W < 1 || ADDR_W > 15) begin : g_bad_addr_w
      $error("otp_byte_mem: ADDR_W must lie in 1..15");
   end
   if (RD_LAT > 255) begin : g_bad_lat
      $error("otp_byte_mem: RD_LAT must not exceed 255");
   end

   otp_mode_e         mode;
   logic              pend;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_data;
   logic              wr_en;
   logic [DATA_W-1:0] arr_byte;
   logic [DATA_W-1:0] out_byte;

   otp_mode_dec u_dec (
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .vpp_hi  (vpp_hi),
      .sig_sel (sig_sel),
      .mode    (mode)
   );

   // program pulse capture: last address/data seen while ce_n was low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_addr <= '0;
         pend_data <= '0;
      end else if (mode == M_PROGRAM) begin
         pend      <= 1'b1;
         pend_addr <= addr;
         pend_data <= din;
      end else begin
         pend      <= 1'b0;
      end
   end

   assign wr_en = pend && ce_n;

   otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase   (erase),
      .wr_en   (wr_en),
      .wr_addr (pend_addr),
      .wr_data (pend_data),
      .rd_addr (addr),
      .rd_data (arr_byte)
   );

   otp_rd_timer #(.RD_LAT(RD_LAT)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .drive (dout_en),
      .valid (dout_valid)
   );

   assign dout_en  = mode_drives(mode);
   assign out_byte = (mode == M_SIG) ? (addr[0] ? DEV_CODE : MFR_CODE) : arr_byte;
   assign dout     = dout_valid ? out_byte : '0;

   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && !vpp_hi) |-> !dout_en); // R4

   AST_WRITE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ce_n && $past(mode) == M_PROGRAM)); // R5

   AST_NO_DRIVE_HV_LOW_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_hi && !ce_n) |-> !dout_en); // R7
endmodule

// File: tb/sim_otp_byte_mem.sv
module sim_otp_byte_mem;
   localparam int AW  = 10;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          vpp_hi = 1'b0;
   logic          sig_sel = 1'b0;
   logic [7:0]    din = '0;
   logic          erase = 1'b0;
   logic [7:0]    dout;
   logic          dout_en;
   logic          dout_valid;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   otp_byte_mem #(.ADDR_W(AW), .RD_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .vpp_hi(vpp_hi), .sig_sel(sig_sel), .din(din), .erase(erase),
      .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
   );

   // entry: {op, address, data, expected}; op 0 program, 1 read, 2 verify, 3 signature
   localparam logic [27:0] VEC [12] = '{
      {2'd0, 10'h005, 8'hA5, 8'h00},   // R5 program A5
      {2'd1, 10'h005, 8'h00, 8'hA5},   // R2 read back
      {2'd0, 10'h005, 8'hF0, 8'h00},   // R6 clear-only merge
      {2'd2, 10'h005, 8'h00, 8'hA0},   // R8 verify shows A0
      {2'd0, 10'h3FF, 8'h0F, 8'h00},   // R5 top address
      {2'd1, 10'h3FF, 8'h00, 8'h0F},   // R2
      {2'd1, 10'h006, 8'h00, 8'hFF},   // R1 untouched word
      {2'd3, 10'h000, 8'h00, 8'h20},   // R9 manufacturer byte
      {2'd3, 10'h001, 8'h00, 8'h8D},   // R9 device byte
      {2'd0, 10'h000, 8'hFF, 8'h00},   // R6 all-ones write
      {2'd1, 10'h000, 8'h00, 8'hFF},   // R6 unchanged
      {2'd2, 10'h3FF, 8'h00, 8'h0F}    // R8
   };

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      vpp_hi = 1'b0; ce_n = 1'b1; oe_n = 1'b1; sig_sel = 1'b0; erase = 1'b0;
   endtask

   task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input bit with_erase);
      @(negedge clk);
      vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0; addr = a; din = d;
      @(negedge clk);
      ce_n = 1'b1; erase = with_erase;
      @(negedge clk);
      erase = 1'b0; vpp_hi = 1'b0;
   endtask

   task automatic fetch(input int kind, input logic [AW-1:0] a, input string tag,
                        output logic [7:0] v);
      go_idle();
      @(negedge clk);
      addr = a;
      case (kind)
         2:       begin vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b0; end
         3:       begin vpp_hi = 1'b0; ce_n = 1'b0; oe_n = 1'b0; sig_sel = 1'b1; end
         default: begin vpp_hi = 1'b0; ce_n = 1'b0; oe_n = 1'b0; sig_sel = 1'b0; end
      endcase
      #2;
      chk(dout_en && !dout_valid && dout == 8'h00, {tag, " R10 wait"},
          {dout_en, dout_valid, 6'b0}, 8'h80);
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      #2;
      chk(dout_en && dout_valid, {tag, " R10 valid"}, {dout_en, dout_valid, 6'b0}, 8'hC0);
      v = dout;
      go_idle();
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired before R1..R12 finished: actual hang expected end");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] got;
      repeat (3) @(negedge clk);
      #2;
      chk(!dout_en && !dout_valid && dout == 8'h00, "R1 reset outputs", dout, 8'h00);
      rst_n = 1'b1;

      fetch(1, 10'h123, "R1 blank word", got);
      chk(got == 8'hFF, "R1 blank word", got, 8'hFF);

      for (int i = 0; i < 12; i++) begin
         logic [1:0]    op;
         logic [AW-1:0] a;
         logic [7:0]    d;
         logic [7:0]    e;
         {op, a, d, e} = VEC[i];
         if (op == 2'd0) begin
            do_prog(a, d, 1'b0);
         end else begin
            fetch(int'(op), a, $sformatf("vec%0d R2/R8/R9", i), got);
            chk(got == e, $sformatf("vec%0d R2/R6/R8/R9 data", i), got, e);
         end
      end

      // R3 output disable
      go_idle();
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 10'h005;
      repeat (LAT + 2) @(posedge clk);
      @(negedge clk); #2;
      chk(!dout_en && !dout_valid && dout == 8'h00, "R3 output disable", dout, 8'h00);

      // R4 standby with oe_n low
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
      repeat (LAT + 2) @(posedge clk);
      @(negedge clk); #2;
      chk(!dout_en && !dout_valid, "R4 standby", {dout_en, dout_valid, 6'b0}, 8'h00);

      // R7 inhibit (both encodings) with a zero byte present
      go_idle();
      @(negedge clk); vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1; addr = 10'h005; din = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      chk(!dout_en, "R7 inhibit no drive", {dout_en, 7'b0}, 8'h00);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      chk(!dout_en, "R7 low/low no drive", {dout_en, 7'b0}, 8'h00);
      fetch(1, 10'h005, "R7", got);
      chk(got == 8'hA0, "R7 word unchanged", got, 8'hA0);

      // R12 pulse closed by oe_n, then ce_n rises
      go_idle();
      @(negedge clk); vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0; addr = 10'h007; din = 8'h00;
      @(negedge clk); oe_n = 1'b0;
      @(negedge clk); ce_n = 1'b1;
      @(negedge clk); vpp_hi = 1'b0; oe_n = 1'b1;
      fetch(1, 10'h007, "R12", got);
      chk(got == 8'hFF, "R12 cancelled pulse", got, 8'hFF);

      // R12 pulse closed by vpp_hi falling
      go_idle();
      @(negedge clk); vpp_hi = 1'b1; oe_n = 1'b1; ce_n = 1'b0; addr = 10'h008; din = 8'h00;
      @(negedge clk); vpp_hi = 1'b0;
      @(negedge clk); ce_n = 1'b1;
      fetch(1, 10'h008, "R12", got);
      chk(got == 8'hFF, "R12 vpp drop", got, 8'hFF);

      // R11 erase at the same edge as a program commit
      do_prog(10'h010, 8'h00, 1'b1);
      fetch(1, 10'h010, "R11", got);
      chk(got == 8'hFF, "R11 erase beats commit", got, 8'hFF);
      fetch(2, 10'h005, "R11", got);
      chk(got == 8'hFF, "R11 earlier word blanked", got, 8'hFF);

      // R5 after erase: program works again
      do_prog(10'h010, 8'h3C, 1'b0);
      fetch(1, 10'h010, "R5", got);
      chk(got == 8'h3C, "R5 program after erase", got, 8'h3C);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule